// File: doc/BRIEF.md
# Metastability-containing ternary multiplexer

This block selects one of 2^K data signals with a K-digit select, where every data signal and every select digit is ternary: stable 0, stable 1, or M (possibly metastable). Each ternary signal travels on two wires. When a select digit is M, the block does not simply give up. It gives a stable value whenever every input that the select could possibly address holds that same stable value. It gives M only when the candidates disagree or when one of them is itself M.

The block is purely combinational and has no clock. It is built recursively. A K-digit instance splits its inputs into a lower half and an upper half, which are told apart by the top address bit. Each half goes to a (K-1)-digit instance that uses the lower select digits. The two results meet in a containing 2:1 cell, which is steered by the top select digit. Unrolled, the tree holds 2^K - 1 such cells.

Top module: `mcm_mux_top`

## Requirements
- R1: The output code is always 2'b00 for stable 0, 2'b11 for stable 1 or 2'b01 for M. The output never carries 2'b10.
- R2: When every select digit is stable, the output equals the addressed data input after normalization, and this holds even when that input is M. Select digit j has weight 2^j. Data input i occupies bits [2i+1:2i] of `data_i`, and select digit j occupies bits [2j+1:2j] of `sel_i`.
- R3: An input code of 2'b10 is treated as M, whether it sits on a data input or on a select digit.
- R4: When every data input the select can address holds the same stable value b, the output is b, even when some select digits are M.
- R5: When the addressable inputs include both 0 and 1, or include any M, the output is M.
- R6: With all select digits at M, the output is stable b exactly when all 2^K inputs equal b. Otherwise it is M.
- R7: The most significant select digit (digit K-1) chooses between the lower half of the inputs (indices below 2^(K-1)) and the upper half. An M on that digit alone still gives a stable result when the two candidates from the halves agree.
- R8: The output follows the inputs combinationally, with no clock or storage in the path.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| data_i | input | 2*2**K | Ternary data inputs. Input i sits at bits [2i+1:2i]. |
| sel_i | input | 2*K | Ternary select. Digit j sits at bits [2j+1:2j], and digit K-1 is the most significant. |
| data_o | output | 2 | Ternary result, using the R1 encoding. |

## Verification
A faulty containing cell or a miswired half only shows up under particular select patterns. A cell that drops the agreement term shows M where b is expected, and only when its own select digit is M and both of its candidates agree. A swapped half or a wrong digit order shows up with stable selects. Since no storage lies in the path, any such fault appears in the same evaluation as the stimulus that exposes it. The bench therefore sweeps select digits through M at every tree level and biases the data towards agreeing candidates, so that each cell's agreement path is driven.

// File: rtl/mcm_pkg.sv
package mcm_pkg;
  typedef logic [1:0] tern_t;

  localparam tern_t TERN_0 = 2'b00;
  localparam tern_t TERN_1 = 2'b11;
  localparam tern_t TERN_M = 2'b01;

  // bit1 = lower bound (surely 1), bit0 = upper bound (may be 1)
  function automatic tern_t tern_fix(tern_t v);
    return {v[1] & v[0], v[1] | v[0]};
  endfunction

  function automatic tern_t tern_and(tern_t a, tern_t b);
    return {a[1] & b[1], a[0] & b[0]};
  endfunction

  function automatic tern_t tern_or(tern_t a, tern_t b);
    return {a[1] | b[1], a[0] | b[0]};
  endfunction

  function automatic tern_t tern_not(tern_t a);
    return {~a[0], ~a[1]};
  endfunction
endpackage

// File: rtl/mcm_tnorm.sv
module mcm_tnorm #(
  parameter int N = 1
) (
  input  logic [2*N-1:0] raw_i,
  output logic [2*N-1:0] fix_o
);
  import mcm_pkg::*;

  for (genvar g = 0; g < N; g++) begin : g_fix
    assign fix_o[2*g +: 2] = tern_fix(raw_i[2*g +: 2]);
  end
endmodule

// File: rtl/mcm_cmux.sv
module mcm_cmux (
  input  logic [1:0] a_i,
  input  logic [1:0] b_i,
  input  logic [1:0] sel_i,
  output logic [1:0] y_o
);
  import mcm_pkg::*;

  tern_t pick_a, pick_b, agree;

  // consensus term a&b keeps the output stable when sel is M
  always_comb begin
    pick_a = tern_and(a_i, tern_not(sel_i));
    pick_b = tern_and(b_i, sel_i);
    agree  = tern_and(a_i, b_i);
    y_o    = tern_or(tern_or(pick_a, pick_b), agree);
  end
endmodule

// File: rtl/mcm_mux_node.sv
module mcm_mux_node #(
  parameter int K = 2
) (
  input  logic [2*(2**K)-1:0] data_i,
  input  logic [2*K-1:0]      sel_i,
  output logic [1:0]          y_o
);
  localparam int HALF_W = 2 * (2**(K-1));

  if (K == 1) begin : g_leaf
    mcm_cmux cell_i (
      .a_i  (data_i[1:0]),
      .b_i  (data_i[3:2]),
      .sel_i(sel_i[1:0]),
      .y_o  (y_o)
    );
  end else begin : g_split
    logic [1:0] lo_y, hi_y;

    mcm_mux_node #(.K(K-1)) lo_i (
      .data_i(data_i[HALF_W-1:0]),
      .sel_i (sel_i[2*(K-1)-1:0]),
      .y_o   (lo_y)
    );

    mcm_mux_node #(.K(K-1)) hi_i (
      .data_i(data_i[2*HALF_W-1:HALF_W]),
      .sel_i (sel_i[2*(K-1)-1:0]),
      .y_o   (hi_y)
    );

    mcm_cmux cell_i (
      .a_i  (lo_y),
      .b_i  (hi_y),
      .sel_i(sel_i[2*K-1:2*K-2]),
      .y_o  (y_o)
    );
  end
endmodule

// File: rtl/mcm_mux_top.sv
module mcm_mux_top #(
  parameter int K = 4
) (
  input  logic [2*(2**K)-1:0] data_i,
  input  logic [2*K-1:0]      sel_i,
  output logic [1:0]          data_o
);
  localparam int NIN = 2**K;

  logic [2*NIN-1:0] data_fix;
  logic [2*K-1:0]   sel_fix;

  mcm_tnorm #(.N(NIN)) dnorm_i (.raw_i(data_i), .fix_o(data_fix));
  mcm_tnorm #(.N(K))   snorm_i (.raw_i(sel_i),  .fix_o(sel_fix));

  mcm_mux_node #(.K(K)) tree_i (
    .data_i(data_fix),
    .sel_i (sel_fix),
    .y_o   (data_o)
  );
endmodule

// File: rtl/mcm_mux_chk.sv
module mcm_mux_chk #(
  parameter int K = 4
) (
  input logic [2*(2**K)-1:0] data_i,
  input logic [2*K-1:0]      sel_i,
  input logic [1:0]          data_o
);
  localparam int NIN = 2**K;

  logic [K-1:0] addr;
  logic         sel_stable, sel_all_m, all_one, all_zero;
  logic [1:0]   picked;

  always_comb begin
    sel_stable = 1'b1;
    sel_all_m  = 1'b1;
    for (int d = 0; d < K; d++) begin
      addr[d] = sel_i[2*d+1];
      if (sel_i[2*d] != sel_i[2*d+1]) sel_stable = 1'b0;
      else                            sel_all_m  = 1'b0;
    end
  end

  always_comb begin
    all_one  = 1'b1;
    all_zero = 1'b1;
    for (int i = 0; i < NIN; i++) begin
      if (data_i[2*i +: 2] != 2'b11) all_one  = 1'b0;
      if (data_i[2*i +: 2] != 2'b00) all_zero = 1'b0;
    end
  end

  always_comb begin
    case (data_i[2*addr +: 2])
      2'b00:   picked = 2'b00;
      2'b11:   picked = 2'b11;
      default: picked = 2'b01;
    endcase
  end

  always_comb begin
    if (!$isunknown({data_i, sel_i, data_o})) begin
      a_r1_legal_code: assert (data_o != 2'b10);
      if (sel_stable)
        a_r2_stable_sel_pass: assert (data_o == picked);
      if (all_one)
        a_r4_all_one: assert (data_o == 2'b11);
      if (all_zero)
        a_r4_all_zero: assert (data_o == 2'b00);
      if (sel_all_m && !all_one && !all_zero)
        a_r6_full_m_sel: assert (data_o == 2'b01);
    end
  end
endmodule

bind mcm_mux_top mcm_mux_chk #(.K(K)) chk_i (
  .data_i(data_i),
  .sel_i (sel_i),
  .data_o(data_o)
);

// File: tb/mcm_mux_top_tb_top.sv
`timescale 1ns/1ps
module mcm_mux_top_tb_top;
  localparam int KA = 4;
  localparam int KB = 2;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic [2*(2**KA)-1:0] data_a;
  logic [2*KA-1:0]      sel_a;
  logic [1:0]           out_a;
  logic [2*(2**KB)-1:0] data_b;
  logic [2*KB-1:0]      sel_b;
  logic [1:0]           out_b;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  mcm_mux_top #(.K(KA)) dut_i (.data_i(data_a), .sel_i(sel_a), .data_o(out_a));
  mcm_mux_top #(.K(KB)) dut_k2_i (.data_i(data_b), .sel_i(sel_b), .data_o(out_b));

  function automatic logic [1:0] ref_mux(input logic [31:0] d, input logic [7:0] s, input int k);
    logic seen0, seen1, seenm, ok;
    logic [1:0] v;
    seen0 = 0; seen1 = 0; seenm = 0;
    for (int r = 0; r < (1 << k); r++) begin
      ok = 1;
      for (int dd = 0; dd < k; dd++) begin
        if (s[2*dd +: 2] == 2'b00 && r[dd])  ok = 0;
        if (s[2*dd +: 2] == 2'b11 && !r[dd]) ok = 0;
      end
      if (ok) begin
        v = d[2*r +: 2];
        if (v == 2'b00)      seen0 = 1;
        else if (v == 2'b11) seen1 = 1;
        else                 seenm = 1;
      end
    end
    if (seenm || (seen0 && seen1)) return 2'b01;
    return seen1 ? 2'b11 : 2'b00;
  endfunction

  function automatic logic [1:0] rand_code(input int m_pct);
    int r;
    r = int'($urandom % 100);
    if (r < m_pct / 2) return 2'b01;
    if (r < m_pct)     return 2'b10;
    return ($urandom % 2) ? 2'b11 : 2'b00;
  endfunction

  task automatic check(input string req, input logic [1:0] act, input logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic apply_a(input logic [31:0] d, input logic [7:0] s, input string req);
    @(posedge clk);
    data_a = d;
    sel_a  = s;
    @(negedge clk);
    check(req, out_a, ref_mux(d, s, KA));
  endtask

  function automatic logic [31:0] fill(input logic [1:0] c);
    logic [31:0] v;
    for (int i = 0; i < 16; i++) v[2*i +: 2] = c;
    return v;
  endfunction

  initial begin
    logic [31:0] d;
    logic [7:0]  s;
    void'($urandom(32'h5eed_0042));
    data_a = '0; sel_a = '0; data_b = '0; sel_b = '0;
    @(negedge clk);
    check("R1 idle zero", out_a, 2'b00);

    // R2 stable select, addressed M passes through
    d = fill(2'b11); d[2*5 +: 2] = 2'b01;
    apply_a(d, 8'b00_11_00_11, "R2 addressed M");
    check("R2 addressed M value", out_a, 2'b01);
    d = fill(2'b00); d[2*9 +: 2] = 2'b11;
    apply_a(d, 8'b11_00_00_11, "R2 stable idx9");
    check("R2 stable idx9 value", out_a, 2'b11);

    // R3 code 10 on data and on a select digit
    d = fill(2'b00); d[2*3 +: 2] = 2'b10;
    apply_a(d, 8'b00_00_11_11, "R3 data 10");
    check("R3 data 10 value", out_a, 2'b01);
    d = fill(2'b00); d[2*1 +: 2] = 2'b11;
    apply_a(d, 8'b00_00_00_10, "R3 sel 10");
    check("R3 sel 10 value", out_a, 2'b01);

    // R4 / R6 all M select
    apply_a(fill(2'b11), 8'b01_01_01_01, "R4 all ones sel M");
    check("R6 all agree value", out_a, 2'b11);
    d = fill(2'b00); d[2*15 +: 2] = 2'b11;
    apply_a(d, 8'b01_01_01_01, "R6 one differs");
    check("R5 disagree value", out_a, 2'b01);

    // R7 most significant digit splits halves
    d = 32'hFFFF_0000;
    apply_a(d, 8'b11_00_00_00, "R7 upper half");
    check("R7 upper value", out_a, 2'b11);
    apply_a(d, 8'b01_00_00_00, "R7 msb M disagree");
    check("R7 msb M value", out_a, 2'b01);
    d = 32'h0000_0000; d[2*8 +: 2] = 2'b00; d[2*1 +: 2] = 2'b11;
    apply_a(d, 8'b01_00_00_00, "R7 msb M agree");
    check("R7 msb M agree value", out_a, 2'b00);

    // R4 lower digit M, candidates agree at 1
    d = fill(2'b00); d[2*12 +: 2] = 2'b11; d[2*13 +: 2] = 2'b11;
    apply_a(d, 8'b11_11_00_01, "R4 low digit M agree");
    check("R4 low digit M value", out_a, 2'b11);

    // R8 output follows inputs without a clock edge
    data_a = fill(2'b00); sel_a = '0;
    #1;
    data_a[1:0] = 2'b11;
    #0.5;
    check("R8 combinational", out_a, 2'b11);

    // R5 R6 random K=4
    for (int it = 0; it < 4000; it++) begin
      logic [1:0] base;
      int mix;
      base = ($urandom % 2) ? 2'b11 : 2'b00;
      mix  = int'($urandom % 4);
      for (int i = 0; i < 16; i++)
        d[2*i +: 2] = (mix == 0) ? rand_code(30) :
                      (($urandom % 16) == 0 ? rand_code(50) : base);
      for (int j = 0; j < KA; j++) s[2*j +: 2] = rand_code(45);
      apply_a(d, s, "R5 random k4");
    end

    // R1..R6 exhaustive K=2
    for (int dv = 0; dv < 256; dv++) begin
      for (int sv = 0; sv < 16; sv++) begin
        @(posedge clk);
        data_b = dv[7:0];
        sel_b  = sv[3:0];
        @(negedge clk);
        check("R1 R5 exhaustive k2", out_b, ref_mux({24'h0, dv[7:0]}, {4'h0, sv[3:0]}, KB));
      end
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule